// File: doc/BRIEF.md
# Two-Phase Peripheral Bus Bridge

This block turns single read and write requests from a simple system-side port into APB (revision 2) transfers. Every transfer has exactly two phases. In the setup phase the bridge drives the address, direction, write data and one peripheral select line. In the enable phase it raises the enable strobe. There is no wait-state or error handshake, so a transfer always occupies exactly two clocks on the peripheral side.

A built-in secondary decoder picks the select line from the upper address bits. The peripheral map is a row of equal-sized windows: slave `i` owns the window whose upper bits equal `(BASE_ADDR >> REGION_BITS) + i`. An address outside every window still runs a two-phase transfer but raises no select line, and a read from it returns zero. Each slave has its own read-data bus. The bridge muxes these buses with the select value it registered for the transfer. It returns the captured word together with a one-cycle done pulse.

To save power, address and direction keep their last values between transfers. Write data changes only when a write is accepted. A new request can be taken either from idle or in the last clock of the enable phase. In the second case the transfers run back to back, with no idle clock between them.

Top module: `apb_bridge`

## Requirements
- R1: While reset is low, and in the first cycle after it, all select lines and the enable strobe are low, done is low and reqReady is high.
- R2: An accepted request puts the bus in setup for exactly one clock: select is active and enable is low. The next clock is always enable.
- R3: pAddr, pWrite and pSel hold the same values in setup and in the following enable clock.
- R4: pEnable is high for exactly one clock per transfer. If reqValid is high during enable, the next clock is setup for the new request with no idle gap. Otherwise the bus returns to idle.
- R5: With default parameters, address bits [31:12] equal to k (k = 0..3) raise only pSel[k]. Any other address raises no select line. At most one select line is high at any time.
- R6: On a read, the bridge captures the read bus of the slave selected for that transfer at the clock edge that ends enable. A read from an unmapped address yields zero. A write leaves rdData unchanged.
- R7: done is high for exactly one cycle, in the cycle right after enable. rdData is valid in that cycle.
- R8: After a transfer, pAddr and pWrite keep their values until the next request is accepted.
- R9: pWdata loads reqWdata only when a write is accepted. Reads and idle cycles leave it unchanged.
- R10: reqReady is high only in idle and in enable. A request presented during setup is ignored and does not change pAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | System request present |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data of the request |
| reqReady | output | 1 | Request taken at the next edge if reqValid is high |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read data of the last completed read |
| pAddr | output | ADDR_W | Peripheral address |
| pWrite | output | 1 | Peripheral direction |
| pWdata | output | DATA_W | Peripheral write data |
| pEnable | output | 1 | Enable phase strobe |
| pSel | output | NUM_SLV | One-hot peripheral selects |
| pRdata | input | NUM_SLV*DATA_W | Read buses, slave i in bits [i*DATA_W +: DATA_W] |

## Verification
The bench drives a request on a falling edge. One clock later it expects setup: the decoded select line and address, enable low and reqReady low. Two clocks later it expects enable with the same address and select, and write data already loaded. Three clocks later it expects done, with the read word taken from the bench's slave model or zero. Every sample is taken on falling edges, and when transfers are chained the done check of one transfer lands in the setup sample of the next.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ENABLE = 2'd2
  } phase_t;

  typedef struct packed {
    logic accept;    // request taken at this edge
    logic inSetup;   // bus in setup phase
    logic inEnable;  // bus in enable phase
  } ctrlStrobe_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        done
);
  phase_t phase, phaseNext;

  assign reqReady        = (phase == PH_IDLE) || (phase == PH_ENABLE);
  assign strobe.accept   = reqValid && reqReady;
  assign strobe.inSetup  = (phase == PH_SETUP);
  assign strobe.inEnable = (phase == PH_ENABLE);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:   if (reqValid) phaseNext = PH_SETUP;
      PH_SETUP:  phaseNext = PH_ENABLE;
      PH_ENABLE: phaseNext = reqValid ? PH_SETUP : PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= (phase == PH_ENABLE);
    end
  end
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          NUM_SLV     = 4,
  parameter int          REGION_BITS = 12,
  parameter logic [31:0] BASE_ADDR   = 32'h0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic                      reqWrite,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [NUM_SLV*DATA_W-1:0] pRdata,
  output logic [ADDR_W-1:0]         pAddr,
  output logic                      pWrite,
  output logic [DATA_W-1:0]         pWdata,
  output logic                      pEnable,
  output logic [NUM_SLV-1:0]        pSel,
  output logic [DATA_W-1:0]         rdData
);
  localparam int TAG_W = ADDR_W - REGION_BITS;
  localparam logic [TAG_W-1:0] BASE_TAG = TAG_W'(BASE_ADDR >> REGION_BITS);

  logic [NUM_SLV-1:0] selDec, selQ;
  logic [DATA_W-1:0]  rdMux;
  logic [TAG_W-1:0]   reqTag;

  assign reqTag = reqAddr[ADDR_W-1:REGION_BITS];

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_decode
    assign selDec[i] = (reqTag == BASE_TAG + TAG_W'(i));
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_SLV; i++)
      if (selQ[i]) rdMux = rdMux | pRdata[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pAddr  <= '0;
      pWrite <= 1'b0;
      pWdata <= '0;
      selQ   <= '0;
      rdData <= '0;
    end else begin
      if (strobe.accept) begin
        pAddr  <= reqAddr;
        pWrite <= reqWrite;
        selQ   <= selDec;
        if (reqWrite) pWdata <= reqWdata;
      end
      if (strobe.inEnable && !pWrite) rdData <= rdMux;
    end
  end

  assign pSel    = (strobe.inSetup || strobe.inEnable) ? selQ : '0;
  assign pEnable = strobe.inEnable;
endmodule

// File: rtl/apb_bridge.sv
module apb_bridge
  import bridge_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          NUM_SLV     = 4,
  parameter int          REGION_BITS = 12,
  parameter logic [31:0] BASE_ADDR   = 32'h0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic                      reqWrite,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      reqReady,
  output logic                      done,
  output logic [DATA_W-1:0]         rdData,
  output logic [ADDR_W-1:0]         pAddr,
  output logic                      pWrite,
  output logic [DATA_W-1:0]         pWdata,
  output logic                      pEnable,
  output logic [NUM_SLV-1:0]        pSel,
  input  logic [NUM_SLV*DATA_W-1:0] pRdata
);
  ctrlStrobe_t strobe;

  bridge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .reqReady (reqReady),
    .done     (done)
  );

  bridge_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_SLV     (NUM_SLV),
    .REGION_BITS (REGION_BITS),
    .BASE_ADDR   (BASE_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .pRdata   (pRdata),
    .pAddr    (pAddr),
    .pWrite   (pWrite),
    .pWdata   (pWdata),
    .pEnable  (pEnable),
    .pSel     (pSel),
    .rdData   (rdData)
  );
endmodule

// File: rtl/apb_bridge_checker.sv
module apb_bridge_checker #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SLV = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               done,
  input logic [ADDR_W-1:0]  pAddr,
  input logic               pWrite,
  input logic               pEnable,
  input logic [NUM_SLV-1:0] pSel
);
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pSel));

  assert_setup_to_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pSel != '0 && !pEnable) |=> pEnable);

  assert_setup_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pSel != '0 && !pEnable) |=> ($stable(pAddr) && $stable(pWrite) && $stable(pSel)));

  assert_single_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |=> !pEnable);

  assert_done_after_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |=> done);

  assert_done_only_after_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pEnable |=> !done);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pEnable && !reqValid) |=> ($stable(pAddr) && $stable(pWrite)));

  assert_ready_in_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |-> reqReady);

  assert_busy_in_setup_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pSel != '0 && !pEnable) |-> !reqReady);
endmodule

bind apb_bridge apb_bridge_checker #(.ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .done     (done),
  .pAddr    (pAddr),
  .pWrite   (pWrite),
  .pEnable  (pEnable),
  .pSel     (pSel)
);

// File: tb/apb_bridge_tb.sv
module apb_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, done, pWrite, pEnable;
  logic [DW-1:0] rdData, pWdata;
  logic [AW-1:0] pAddr;
  logic [NS-1:0] pSel;
  logic [NS*DW-1:0] pRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit pendDone = 0;
  logic [DW-1:0] expRd = '0;
  logic [DW-1:0] lastW = '0;
  logic [AW-1:0] lastA = '0;
  bit lastWr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_bridge u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqReady(reqReady),
    .done(done), .rdData(rdData), .pAddr(pAddr), .pWrite(pWrite),
    .pWdata(pWdata), .pEnable(pEnable), .pSel(pSel), .pRdata(pRdata)
  );

  function automatic logic [DW-1:0] slaveVal(int i, logic [AW-1:0] a);
    return {8'hA5, 4'(i), 4'h3, a[15:0]};
  endfunction

  function automatic logic [NS-1:0] expSel(logic [AW-1:0] a);
    if (a[31:14] == '0) return NS'(1) << a[13:12];
    return '0;
  endfunction

  function automatic logic [DW-1:0] expRead(logic [AW-1:0] a);
    logic [NS-1:0] s = expSel(a);
    for (int i = 0; i < NS; i++) if (s[i]) return slaveVal(i, a);
    return '0;
  endfunction

  always_comb
    for (int i = 0; i < NS; i++) pRdata[i*DW +: DW] = slaveVal(i, pAddr);

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkDone();
    if (pendDone) begin
      check(done === 1'b1, "R7", "done pulse", 32'(done), 1);
      check(rdData === expRd, "R6", "read data", rdData, expRd);
    end else begin
      check(done === 1'b0, "R7", "no done", 32'(done), 0);
    end
    pendDone = 0;
  endtask

  // caller is at a falling edge with reqReady high
  task automatic issue(logic [AW-1:0] a, bit w, logic [DW-1:0] d);
    reqValid = 1; reqAddr = a; reqWrite = w; reqWdata = d;
    tick();
    checkDone();
    check(pSel === expSel(a), "R5", "decoded select", 32'(pSel), 32'(expSel(a)));
    check(pEnable === 1'b0, "R2", "setup enable low", 32'(pEnable), 0);
    check(pAddr === a && pWrite === w, "R2", "setup address", pAddr, a);
    check(reqReady === 1'b0, "R10", "ready low in setup", 32'(reqReady), 0);
    // request during setup must be ignored
    reqValid = 1'($urandom_range(0, 1)); reqAddr = $urandom; reqWrite = ~w;
    reqWdata = $urandom;
    tick();
    check(pEnable === 1'b1, "R2", "enable follows setup", 32'(pEnable), 1);
    check(pSel === expSel(a) && pAddr === a && pWrite === w, "R3", "stable address/select",
          pAddr, a);
    check(reqReady === 1'b1, "R10", "ready in enable", 32'(reqReady), 1);
    if (w) lastW = d;
    check(pWdata === lastW, "R9", "write data", pWdata, lastW);
    check(done === 1'b0, "R7", "no done in enable", 32'(done), 0);
    if (!w) expRd = expRead(a);
    pendDone = 1; lastA = a; lastWr = w;
    reqValid = 0;
  endtask

  task automatic idle();
    reqValid = 0; reqAddr = $urandom; reqWrite = $urandom_range(0, 1);
    tick();
    checkDone();
    check(pSel === '0 && pEnable === 1'b0, "R4", "idle after enable", 32'(pSel), 0);
    check(pAddr === lastA && pWrite === lastWr, "R8", "address held", pAddr, lastA);
    check(pWdata === lastW, "R9", "write data held", pWdata, lastW);
  endtask

  function automatic logic [AW-1:0] randAddr();
    int r = $urandom_range(0, 4);
    if (r < 4) return (AW'(r) << 12) | AW'($urandom & 32'hFFC);
    return 32'h0010_0000 | AW'($urandom & 32'hFFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pSel === '0 && pEnable === 1'b0 && done === 1'b0 && reqReady === 1'b1,
          "R1", "in reset", {pSel, 1'b0, pEnable, done, reqReady}, 32'h1);
    rstN = 1;
    @(negedge clk);
    check(pSel === '0 && pEnable === 1'b0 && done === 1'b0 && reqReady === 1'b1,
          "R1", "after reset", {pSel, 1'b0, pEnable, done, reqReady}, 32'h1);

    // directed: write, unmapped read, back-to-back reads on each slave
    issue(32'h0000_2010, 1, 32'hDEAD_BEEF); idle();
    issue(32'h0040_0000, 0, 32'h0);         idle(); // R6 unmapped read -> 0
    issue(32'h0000_0004, 0, 32'h0);
    issue(32'h0000_1008, 0, 32'h0);
    issue(32'h0000_200C, 0, 32'h0);
    issue(32'h0000_3FFC, 0, 32'h0);         idle(); // R4 chained transfers
    issue(32'h0000_3000, 1, 32'h1234_5678); idle(); // R6 write keeps rdData
    issue(32'h0000_1000, 0, 32'h0);         idle(); // R9 read keeps pWdata
    repeat (2) idle();

    for (int k = 0; k < 400; k++) begin
      issue(randAddr(), 1'($urandom_range(0, 1)), $urandom);
      if ($urandom_range(0, 1) == 0) begin
        for (int g = 0; g < int'($urandom_range(1, 3)); g++) idle();
      end
    end
    idle();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule